// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a 48-bit virtual address into a physical address. It reads a tree of 64-bit descriptors held in memory, using a 4 KB granule. A client hands it one translation request, made of the virtual address and the base of the root table. The walker then issues one 8-byte read per level on a simple memory port and decodes each descriptor as it returns. A walk ends in one of three ways: at a 4 KB page on the last level, early at a 1 GB or 2 MB block descriptor, or at the first descriptor that cannot be used.

The answer comes back as a single response beat. It carries either the physical address together with the attribute fields of the final descriptor, or a fault flag with a fault code and the level where the walk stopped. Caching of finished translations, permission checks and cache maintenance are left to the surrounding logic.

The request, memory-read and response channels are all valid/ready streams:
- **Request channel.** `req_ready` is high only while no walk is in flight, so a second request is held off until the previous response has been taken.
- **Memory-read channel.** A read request holds its address until `mem_req_ready` is seen. The read data returns later as a one-cycle `mem_rsp_valid` pulse, with no back-pressure.
- **Response channel.** A response stays on the port, unchanged, for as long as `rsp_ready` is low.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: Each level reads the entry at address {table base bits [47:12], index, 3'b000}. The index is VA[47:39] at level 0, VA[38:30] at level 1, VA[29:21] at level 2 and VA[20:12] at level 3. Bits [11:0] of the root base supplied with the request are ignored.
- R3: At levels 0, 1 and 2, a descriptor whose low bits [1:0] are 2'b11 is a table descriptor. The walk continues at the next level, using descriptor bits [47:12] as that level's table base.
- R4: At level 1, low bits 2'b01 are a 1 GB block, and the PA is {desc[47:30], VA[29:0]}. At level 2, low bits 2'b01 are a 2 MB block, and the PA is {desc[47:21], VA[20:0]}. Descriptor bits below the block alignment are ignored.
- R5: At level 3, low bits 2'b11 are a 4 KB page, and the PA is {desc[47:12], VA[11:0]}.
- R6: A descriptor with bit 0 clear ends the walk with a translation fault. The fault code is 6'h04 plus the level, and `rsp_level` reports that level.
- R7: Low bits 2'b01 at level 0 or at level 3 end the walk with a translation fault (code 6'h04 plus the level). A successful walk therefore never ends at level 0.
- R8: A final block or page descriptor with bit 10 (the access flag) clear gives a fault with code 6'h21 at that level. A descriptor that is both unusable by type and missing its access flag reports the translation fault, not the access-flag fault.
- R9: On success, the response carries the final descriptor's fields: `rsp_attr_idx` = bits [4:2], `rsp_ap` = bits [7:6], `rsp_sh` = bits [9:8], `rsp_pxn` = bit 53 and `rsp_uxn` = bit 54. On any fault, the PA and all attribute outputs are 0.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the read address holds. While `rsp_valid` is high and `rsp_ready` is low, every response field holds. `req_ready` is never high together with `mem_req_valid` or `rsp_valid`.
- R11: A walk issues exactly one memory read per level it visits, and no more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request taken when both are high |
| req_va | input | 48 | Virtual address to translate |
| req_root | input | 48 | Root table base (low 12 bits ignored) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_data | input | 64 | Descriptor read from memory |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 6 | 6'h04+level translation fault, 6'h21 access-flag fault |
| rsp_level | output | 2 | Level at which the walk ended |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| rsp_attr_idx | output | 3 | Memory attribute index |
| rsp_sh | output | 2 | Shareability field |
| rsp_ap | output | 2 | Access permission field |
| rsp_pxn | output | 1 | Privileged execute-never |
| rsp_uxn | output | 1 | Unprivileged execute-never |

## Verification
Two checks are resolved in the same decode cycle: the type check (valid bit and whether the low bits suit the level) and the access-flag check. The bench provokes the clash with last-level descriptors that carry the block encoding and a clear access flag, and expects the translation fault code to win over 6'h21. A second overlap concerns the response and the next request. The bench holds `rsp_ready` low for several cycles on every walk and requires that the response fields do not move and that `req_ready` stays low. At the same time, the memory port stalls reads and varies the read latency, and every address issued is compared against an address queue predicted by a behavioural walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DECODE,
    ST_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_INVALID,
    DK_TABLE,
    DK_LEAF,
    DK_BADTYPE
  } desc_kind_e;

  typedef struct packed {
    logic [2:0] attr_idx;
    logic [1:0] sh;
    logic [1:0] ap;
    logic       pxn;
    logic       uxn;
  } leaf_attr_t;

  localparam int unsigned FC_W = 6;
  localparam logic [FC_W-1:0] FC_XLAT_BASE   = 6'h04;
  localparam logic [FC_W-1:0] FC_ACCESS_FLAG = 6'h21;

  // descriptor field positions
  localparam int unsigned AF_BIT       = 10;
  localparam int unsigned ATTR_LSB     = 2;
  localparam int unsigned AP_LSB       = 6;
  localparam int unsigned SH_LSB       = 8;
  localparam int unsigned PXN_BIT      = 53;
  localparam int unsigned UXN_BIT      = 54;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned PA_W       = 48,
  parameter int unsigned GRAN_SHIFT = 12,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned LVL_W      = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  table_base,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);

  localparam int unsigned ENTRY_SHIFT = GRAN_SHIFT - IDX_W;

  logic [IDX_W-1:0] idx_by_lvl [LEVELS];

  // level 0 uses the highest index slice, the last level the lowest
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_lvl[g] = va[GRAN_SHIFT + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign entry_addr = {table_base[PA_W-1:GRAN_SHIFT], idx_by_lvl[level],
                       {ENTRY_SHIFT{1'b0}}};

  logic unused_addr_bits;
  assign unused_addr_bits = ^{va[GRAN_SHIFT-1:0], table_base[GRAN_SHIFT-1:0]};

endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W          = 48,
  parameter int unsigned PA_W          = 48,
  parameter int unsigned DESC_W        = 64,
  parameter int unsigned GRAN_SHIFT    = 12,
  parameter int unsigned IDX_W         = 9,
  parameter int unsigned LEVELS        = 4,
  parameter int unsigned LVL_W         = 2,
  parameter int unsigned MIN_BLOCK_LVL = 1
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [LVL_W-1:0]  level,
  input  logic [VA_W-1:0]   va,
  output desc_kind_e        kind,
  output logic [PA_W-1:0]   next_base,
  output logic [PA_W-1:0]   leaf_pa,
  output logic              af,
  output leaf_attr_t        attr
);

  localparam int unsigned LAST_LVL = LEVELS - 1;

  logic [PA_W-1:0] off_mask [LEVELS];
  logic [PA_W-1:0] mask;
  logic [PA_W-1:0] va_pa;
  logic            is_last;
  logic            block_ok;

  // offset width grows by one index field per level above the last
  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign off_mask[g] = (PA_W'(1) << (GRAN_SHIFT + IDX_W*(LAST_LVL-g))) - PA_W'(1);
  end

  assign mask     = off_mask[level];
  assign va_pa    = PA_W'(va);
  assign is_last  = (level == LVL_W'(LAST_LVL));
  assign block_ok = (level >= LVL_W'(MIN_BLOCK_LVL)) && !is_last;

  always_comb begin
    if (!desc[0])      kind = DK_INVALID;
    else if (desc[1])  kind = is_last ? DK_LEAF : DK_TABLE;
    else               kind = block_ok ? DK_LEAF : DK_BADTYPE;
  end

  assign next_base = {desc[PA_W-1:GRAN_SHIFT], {GRAN_SHIFT{1'b0}}};
  assign leaf_pa   = (desc[PA_W-1:0] & ~mask) | (va_pa & mask);
  assign af        = desc[AF_BIT];

  assign attr.attr_idx = desc[ATTR_LSB +: 3];
  assign attr.ap       = desc[AP_LSB +: 2];
  assign attr.sh       = desc[SH_LSB +: 2];
  assign attr.pxn      = desc[PXN_BIT];
  assign attr.uxn      = desc[UXN_BIT];

  logic unused_desc_bits;
  assign unused_desc_bits = ^{desc[DESC_W-1:UXN_BIT+1], desc[PXN_BIT-1:PA_W],
                              desc[11], desc[5]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W          = 48,
  parameter int unsigned PA_W          = 48,
  parameter int unsigned DESC_W        = 64,
  parameter int unsigned GRAN_SHIFT    = 12,
  parameter int unsigned IDX_W         = 9,
  parameter int unsigned LEVELS        = 4,
  parameter int unsigned MIN_BLOCK_LVL = 1,
  localparam int unsigned LVL_W        = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   req_root,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [5:0]        rsp_fault_code,
  output logic [LVL_W-1:0]  rsp_level,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_attr_idx,
  output logic [1:0]        rsp_sh,
  output logic [1:0]        rsp_ap,
  output logic              rsp_pxn,
  output logic              rsp_uxn
);

  walk_state_e       state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic [DESC_W-1:0] desc_q;
  logic              fault_q;
  logic [FC_W-1:0]   code_q;
  logic [LVL_W-1:0]  end_lvl_q;
  logic [PA_W-1:0]   pa_q;
  leaf_attr_t        attr_q;

  desc_kind_e        dec_kind;
  logic [PA_W-1:0]   dec_next_base;
  logic [PA_W-1:0]   dec_leaf_pa;
  logic              dec_af;
  leaf_attr_t        dec_attr;

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .GRAN_SHIFT(GRAN_SHIFT),
    .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) i_addr_gen (
    .va         (va_q),
    .table_base (base_q),
    .level      (lvl_q),
    .entry_addr (mem_req_addr)
  );

  ptw_desc_decode #(
    .VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W), .GRAN_SHIFT(GRAN_SHIFT),
    .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W), .MIN_BLOCK_LVL(MIN_BLOCK_LVL)
  ) i_desc_decode (
    .desc      (desc_q),
    .level     (lvl_q),
    .va        (va_q),
    .kind      (dec_kind),
    .next_base (dec_next_base),
    .leaf_pa   (dec_leaf_pa),
    .af        (dec_af),
    .attr      (dec_attr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lvl_q     <= '0;
      va_q      <= '0;
      base_q    <= '0;
      desc_q    <= '0;
      fault_q   <= 1'b0;
      code_q    <= '0;
      end_lvl_q <= '0;
      pa_q      <= '0;
      attr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            base_q  <= {req_root[PA_W-1:GRAN_SHIFT], {GRAN_SHIFT{1'b0}}};
            lvl_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            desc_q  <= mem_rsp_data;
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          end_lvl_q <= lvl_q;
          unique case (dec_kind)
            DK_TABLE: begin
              base_q  <= dec_next_base;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= ST_FETCH;
            end
            DK_LEAF: begin
              state_q <= ST_RESP;
              if (dec_af) begin
                fault_q <= 1'b0;
                code_q  <= '0;
                pa_q    <= dec_leaf_pa;
                attr_q  <= dec_attr;
              end else begin
                fault_q <= 1'b1;
                code_q  <= FC_ACCESS_FLAG;
                pa_q    <= '0;
                attr_q  <= '0;
              end
            end
            default: begin
              // invalid entry or a type that this level does not allow
              state_q <= ST_RESP;
              fault_q <= 1'b1;
              code_q  <= FC_XLAT_BASE + FC_W'(lvl_q);
              pa_q    <= '0;
              attr_q  <= '0;
            end
          endcase
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign mem_req_valid  = (state_q == ST_FETCH);
  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_fault      = fault_q;
  assign rsp_fault_code = code_q;
  assign rsp_level      = end_lvl_q;
  assign rsp_pa         = pa_q;
  assign rsp_attr_idx   = attr_q.attr_idx;
  assign rsp_sh         = attr_q.sh;
  assign rsp_ap         = attr_q.ap;
  assign rsp_pxn        = attr_q.pxn;
  assign rsp_uxn        = attr_q.uxn;

  logic unused_root_bits;
  assign unused_root_bits = ^req_root[GRAN_SHIFT-1:0];

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_fault, rsp_fault_code, rsp_level, rsp_pa, rsp_attr_idx,
               rsp_sh, rsp_ap, rsp_pxn, rsp_uxn})); // R10

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid); // R10

  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_attr_idx == '0 &&
      rsp_sh == '0 && rsp_ap == '0 && !rsp_pxn && !rsp_uxn); // R9

  AST_NO_ROOT_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_level != '0); // R7

  AST_AF_AT_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault && rsp_fault_code == FC_ACCESS_FLAG
      |-> rsp_level >= LVL_W'(MIN_BLOCK_LVL)); // R8

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_va;
  logic [47:0] req_root;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [5:0]  rsp_fault_code;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_pa;
  logic [2:0]  rsp_attr_idx;
  logic [1:0]  rsp_sh;
  logic [1:0]  rsp_ap;
  logic        rsp_pxn;
  logic        rsp_uxn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_va, .req_root,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .rsp_valid, .rsp_ready, .rsp_fault, .rsp_fault_code, .rsp_level, .rsp_pa,
    .rsp_attr_idx, .rsp_sh, .rsp_ap, .rsp_pxn, .rsp_uxn
  );

  logic [63:0] mem [bit [47:0]];
  bit   [47:0] exp_q [$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          rsp_cnt = 0;
  bit   [47:0] pend_addr;
  bit          finished = 0;

  function automatic logic [63:0] rd(bit [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model: stalls reads, varies latency, compares every address (R2, R11)
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
    mem_rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
      end
    end
    mem_req_ready = rst_n && ((cyc % 3) != 1);
    if (mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        check_eq("R11", "unexpected read", {16'h0, mem_req_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        check_eq("R2", "entry address", {16'h0, mem_req_addr}, {16'h0, exp_q.pop_front()});
      end
      pend_addr = mem_req_addr;
      rsp_cnt   = 1 + (cyc % 3);
    end
  end

  function automatic bit [47:0] mkva(int l0, int l1, int l2, int l3, int off);
    return (48'(l0) << 39) | (48'(l1) << 30) | (48'(l2) << 21) | (48'(l3) << 12) | 48'(off);
  endfunction

  // behavioural walk: fills the expected address queue and the expected result
  task automatic ref_walk(input bit [47:0] va, input bit [47:0] root,
                          output bit e_fault, output bit [5:0] e_code,
                          output bit [1:0] e_lvl, output bit [47:0] e_pa,
                          output bit [8:0] e_attr);
    bit [47:0] base = root & ~48'hFFF;
    bit        done = 0;
    e_fault = 0; e_code = 0; e_lvl = 0; e_pa = 0; e_attr = 0;
    for (int lvl = 0; lvl < 4 && !done; lvl++) begin
      bit [47:0] idx  = (va >> (39 - 9*lvl)) & 48'h1FF;
      bit [47:0] addr = base + idx*8;
      logic [63:0] d;
      exp_q.push_back(addr);
      d = rd(addr);
      e_lvl = 2'(lvl);
      if (!d[0]) begin
        e_fault = 1; e_code = 6'h04 + 6'(lvl); done = 1;
      end else if (d[1] && lvl < 3) begin
        base = d[47:0] & ~48'hFFF;
      end else if (!d[1] && (lvl == 0 || lvl == 3)) begin
        e_fault = 1; e_code = 6'h04 + 6'(lvl); done = 1;
      end else begin
        bit [47:0] m = (48'h1 << (12 + 9*(3-lvl))) - 1;
        done = 1;
        if (!d[10]) begin
          e_fault = 1; e_code = 6'h21;
        end else begin
          e_pa   = (d[47:0] & ~m) | (va & m);
          e_attr = {d[4:2], d[9:8], d[7:6], d[53], d[54]};
        end
      end
    end
  endtask

  task automatic run_walk(string tag, bit [47:0] va, bit [47:0] root);
    bit e_fault; bit [5:0] e_code; bit [1:0] e_lvl; bit [47:0] e_pa; bit [8:0] e_attr;
    logic [63:0] snap;
    int guard = 0;
    ref_walk(va, root, e_fault, e_code, e_lvl, e_pa, e_attr);
    @(negedge clk);
    check_eq("R10", {tag, " ready before request"}, 64'(req_ready), 64'h1);
    req_valid = 1; req_va = va; req_root = root; rsp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    snap = {rsp_fault, rsp_fault_code, rsp_level, rsp_pa[47:0] ^ {39'h0, rsp_attr_idx, rsp_sh, rsp_ap, rsp_pxn, rsp_uxn}};
    repeat (3) @(negedge clk);
    check_eq("R10", {tag, " response held"},
             {rsp_fault, rsp_fault_code, rsp_level, rsp_pa[47:0] ^ {39'h0, rsp_attr_idx, rsp_sh, rsp_ap, rsp_pxn, rsp_uxn}}, snap);
    check_eq("R10", {tag, " busy blocks request"}, {62'h0, rsp_valid, req_ready}, 64'h2);
    check_eq(tag, "fault", 64'(rsp_fault), 64'(e_fault));
    check_eq(tag, "fault code", 64'(rsp_fault_code), 64'(e_code));
    check_eq(tag, "level", 64'(rsp_level), 64'(e_lvl));
    check_eq(tag, "pa (R9 zero on fault)", 64'(rsp_pa), 64'(e_pa));
    check_eq("R9", {tag, " attributes"},
             64'({rsp_attr_idx, rsp_sh, rsp_ap, rsp_pxn, rsp_uxn}), 64'(e_attr));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check_eq("R11", {tag, " reads left"}, 64'(exp_q.size()), 64'h0);
    check_eq("R10", {tag, " idle after take"}, {62'h0, rsp_valid, req_ready}, 64'h1);
  endtask

  localparam bit [47:0] ROOT = 48'h0010_0000;
  localparam bit [47:0] L1T  = 48'h0020_0000;
  localparam bit [47:0] L2T  = 48'h0030_0000;
  localparam bit [47:0] L3T  = 48'h0050_0000;
  localparam logic [63:0] AFB = 64'h400;

  initial begin
    rst_n = 0; req_valid = 0; req_va = 0; req_root = 0; rsp_ready = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;

    mem[ROOT + 0*8] = {16'h0, L1T} | 64'h3;
    mem[ROOT + 1*8] = 64'h8000_0000 | 64'h1 | AFB;
    mem[L1T + 0*8]  = 64'h1234_5000 | 64'h1 | AFB | (64'h2 << 2) | (64'h3 << 8);
    mem[L1T + 1*8]  = {16'h0, L2T} | 64'h3;
    mem[L1T + 2*8]  = 64'h4000_0400;
    mem[L1T + 3*8]  = 64'hC000_0000 | 64'h1 | (64'h1 << 2);
    mem[L2T + 0*8]  = 64'h4000_0000 | 64'h1 | AFB | (64'h1 << 53) | (64'h1 << 54)
                      | (64'h1 << 6) | (64'h2 << 8) | (64'h5 << 2);
    mem[L2T + 1*8]  = {16'h0, L3T} | 64'h3;
    mem[L2T + 4*8]  = 64'h0ABC_DE7F_F000 | 64'h1 | AFB | (64'h1 << 7);
    mem[L3T + 0*8]  = 64'h8765_4000 | 64'h3 | AFB | (64'h3 << 2) | (64'h1 << 7) | (64'h1 << 53);
    mem[L3T + 1*8]  = 64'h8765_5000 | 64'h1 | AFB;
    mem[L3T + 2*8]  = 64'h8765_6000 | 64'h3;
    mem[L3T + 3*8]  = 64'h8765_7000 | 64'h1;

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R1", "reset handshake state",
             {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

    run_walk("R4 1GB block", mkva(0, 0, 9'h1A5, 9'h0F3, 12'hABC), ROOT);
    run_walk("R4 2MB block", mkva(0, 1, 0, 9'h123, 12'h456), ROOT);
    run_walk("R4 2MB masked base", mkva(0, 1, 4, 9'h1FF, 12'hFFF), ROOT);
    run_walk("R3 R5 4KB page", mkva(0, 1, 1, 0, 12'h321), ROOT);
    run_walk("R6 invalid L1", mkva(0, 2, 7, 7, 7), ROOT);
    run_walk("R6 invalid L0", mkva(2, 0, 0, 0, 0), ROOT);
    run_walk("R7 block at L0", mkva(1, 5, 5, 5, 5), ROOT);
    run_walk("R7 block at L3", mkva(0, 1, 1, 1, 12'h010), ROOT);
    run_walk("R8 page without AF", mkva(0, 1, 1, 2, 0), ROOT);
    run_walk("R8 type fault beats AF", mkva(0, 1, 1, 3, 0), ROOT);
    run_walk("R8 L1 block without AF", mkva(0, 3, 0, 0, 0), ROOT);
    run_walk("R2 root low bits ignored", mkva(0, 1, 1, 0, 12'h321), ROOT | 48'hABC);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule